// File: doc/BRIEF.md
# Resistive touch ADC scan sequencer

This block drives an eight-input touchscreen converter over a four-wire serial link, acting as the bus master in clock mode 0. A single start pulse begins one scan. At start the block captures a channel-enable mask and, for each channel, a settling-discard count and an oversampling ratio. The scan then visits every enabled channel from the lowest address to the highest, all under one chip-select assertion. Channels that are not enabled are passed over.

Each visited channel gets a burst of 24-bit frames. A frame is an 8-bit command followed by a 16-bit response, and the block builds the command byte itself. The leading settling frames of a burst are thrown away. The 12-bit results of the remaining frames are summed, and the sum is divided by the number of kept frames with the quotient rounded upward. The block reports one averaged value per enabled channel, tagged with its channel address. A one-cycle done strobe follows the last value, in the same cycle that chip select is released.

The serial clock is the system clock divided by a parameter. MOSI is updated while SCLK is low, and MISO is captured on the rising SCLK edge.

Top module: `touch_scan_seq`

## Requirements
- R1: `cs_n` falls on the clock edge that accepts `start` and stays low, with no rise, until the edge that raises `scan_done`. `sclk` is never high while `cs_n` is high.
- R2: The link runs in clock mode 0. `sclk` idles low. `mosi` changes only while `sclk` is low, most significant bit first. `miso` is captured on each rising `sclk` edge.
- R3: Every command byte has bit 7 set, the channel address in bits 6:4 and bit 3 clear. Bits 2 and 1 are both set for addresses 0, 2, 6 and 7, and both clear for addresses 1, 3, 4 and 5.
- R4: Bit 0 of the command byte is 1 on every frame of a channel's burst except the last one, where it is 0.
- R5: A channel's burst has skip + ratio frames, and each frame is exactly 24 `sclk` periods. A ratio field of 0 acts as a ratio of 1.
- R6: A sample is taken from response bits 14:3, where response bit 15 is the first bit received after the command. Response bit 15, bits 2:0, and every bit of the first skip frames of a burst have no effect on the reported value.
- R7: The reported value equals the sum of the kept samples divided by the kept count, rounded up. This holds up to full scale 4095 at the largest ratio, with no overflow.
- R8: One `res_valid` pulse is issued for each enabled channel, in ascending address order, with `res_chan` set to that channel. Channels that are not enabled get neither frames nor results.
- R9: `scan_done` pulses for one cycle after the last result, with `busy` low and `cs_n` high. An all-zero mask still gives `scan_done` and produces no `sclk` edge.
- R10: `start` and changes to `chan_en`, `skip_cfg` or `ratio_cfg` while `busy` is high have no effect on the scan in progress, and do not start a new scan.
- R11: After reset, `cs_n` is 1 and `sclk`, `mosi`, `busy`, `res_valid` and `scan_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan; accepted only when idle |
| chan_en | input | NCH | Channel-enable mask, bit n enables address n |
| skip_cfg | input | NCH*SKIP_W | Settling frames to discard, field n for channel n |
| ratio_cfg | input | NCH*RATIO_W | Kept frames to average, field n for channel n (0 acts as 1) |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select, held low for a whole scan |
| busy | output | 1 | High while a scan is in progress |
| res_valid | output | 1 | One-cycle strobe marking a channel result |
| res_chan | output | 3 | Channel address of the result |
| res_data | output | 12 | Averaged 12-bit result |
| scan_done | output | 1 | One-cycle strobe at the end of a scan |

## Verification
Several properties are checked on every cycle: chip select covers every serial clock high phase, MOSI holds steady through each high phase, results arrive in strictly rising channel order and only for enabled channels, the configuration stays frozen during a scan, and every divider quotient is the ceiling of its dividend over its divisor. Other behaviour only the bench scenarios can show. This covers the exact command bytes and power-bit pattern of each burst, the per-channel frame and clock counts, the removal of settling samples and of the padding bits in the response, and full-scale averaging at the largest ratio. It also covers the all-zero mask and a start pulse issued during a scan. A slave model answers every frame with a value derived from the channel and the frame's position in the scan, so each averaged result can be predicted arithmetically.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int FRAME_W    = 24;  // command plus response, in serial bits
   localparam int CMD_W      = 8;
   localparam int SAMPLE_W   = 12;
   localparam int SAMPLE_LSB = 3;   // padding bits below the sample in the response
   localparam int ADDR_W     = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_ISSUE,
      ST_WAIT,
      ST_DIVIDE,
      ST_FINISH
   } seq_state_t;

   // Inputs whose conversion is referenced to ground need the reference powered.
   function automatic logic ref_single_ended(input logic [ADDR_W-1:0] addr);
      logic se;
      case (addr)
         3'd0, 3'd2, 3'd6, 3'd7: se = 1'b1;
         default:                se = 1'b0;
      endcase
      return se;
   endfunction

   // Command byte: start, address, 12-bit mode, reference select, reference on, converter on.
   function automatic logic [CMD_W-1:0] make_cmd(input logic [ADDR_W-1:0] addr,
                                                 input logic              hold_on);
      logic se;
      se = ref_single_ended(addr);
      return {1'b1, addr, 1'b0, se, se, hold_on};
   endfunction
endpackage

// File: rtl/tsc_spi_frame.sv
module tsc_spi_frame
   import tsc_pkg::*;
#(
   parameter int HALF_DIV = 2   // system cycles per serial clock half period
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic [CMD_W-1:0]    cmd,
   input  logic                miso,
   output logic                sclk,
   output logic                mosi,
   output logic [SAMPLE_W-1:0] sample,
   output logic                done
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int BIT_W = $clog2(FRAME_W);
   localparam int CAP_W = SAMPLE_LSB + SAMPLE_W;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("tsc_spi_frame: HALF_DIV must be at least 1");
   end

   logic             active;
   logic             tick;
   logic             sclk_q;
   logic             done_q;
   logic [FRAME_W-1:0] tx_sh;
   logic [CAP_W-1:0] rx_sh;
   logic [BIT_W-1:0] bit_q;

   // Half-period pacing: either every cycle or every HALF_DIV cycles.
   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = active;
   end else begin : g_div
      logic [DIV_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (!active || tick) cnt_q <= '0;
         else                     cnt_q <= cnt_q + 1'b1;
      end
      assign tick = active && (cnt_q == DIV_W'(HALF_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         bit_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               sclk_q <= 1'b0;
               bit_q  <= '0;
               tx_sh  <= {cmd, {(FRAME_W - CMD_W){1'b0}}};
            end
         end else if (tick) begin
            if (!sclk_q) begin
               // rising edge: capture the line
               sclk_q <= 1'b1;
               rx_sh  <= {rx_sh[CAP_W-2:0], miso};
            end else begin
               // falling edge: present the next bit
               sclk_q <= 1'b0;
               tx_sh  <= {tx_sh[FRAME_W-2:0], 1'b0};
               if (bit_q == BIT_W'(FRAME_W - 1)) begin
                  active <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sclk   = sclk_q;
   assign mosi   = tx_sh[FRAME_W-1];
   assign sample = rx_sh[SAMPLE_LSB +: SAMPLE_W];
   assign done   = done_q;

   // R2: data never moves during a high phase of the serial clock
   a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> $stable(mosi));

   // R5: a new frame is only requested once the previous one has ended
   a_r5_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !active);

   // R5: the frame ends on a falling edge
   a_r5_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !sclk_q && $past(sclk_q));
endmodule

// File: rtl/tsc_ceil_div.sv
module tsc_ceil_div #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 4,
   parameter int Q_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0] divisor,
   output logic             done,
   output logic [Q_W-1:0]   quotient
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int STEP_W = $clog2(NUM_W + 1);
   localparam int PRD_W  = NUM_W + DEN_W;

   if (Q_W > NUM_W || DEN_W < 1 || NUM_W < 2) begin : g_bad_width
      $error("tsc_ceil_div: inconsistent widths");
   end

   logic [NUM_W-1:0]  num_q;
   logic [NUM_W-1:0]  dvd_q;
   logic [DEN_W-1:0]  rem_q;
   logic [DEN_W-1:0]  den_q;
   logic [STEP_W-1:0] step_q;
   logic              run_q;
   logic              done_q;
   logic [DEN_W:0]    trial;
   logic [DEN_W:0]    diff;
   logic              fits;

   assign trial = {rem_q, num_q[NUM_W-1]};
   assign diff  = trial - {1'b0, den_q};
   assign fits  = (trial >= {1'b0, den_q});

   // Restoring division of (dividend + divisor - 1), one quotient bit per cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q  <= '0;
         dvd_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         step_q <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            num_q  <= dividend + NUM_W'(divisor) - NUM_W'(1);
            dvd_q  <= dividend;
            den_q  <= divisor;
            rem_q  <= '0;
            step_q <= STEP_W'(NUM_W);
            run_q  <= 1'b1;
         end else if (run_q) begin
            if (fits) begin
               rem_q <= diff[DEN_W-1:0];
               num_q <= {num_q[NUM_W-2:0], 1'b1};
            end else begin
               rem_q <= trial[DEN_W-1:0];
               num_q <= {num_q[NUM_W-2:0], 1'b0};
            end
            step_q <= step_q - 1'b1;
            if (step_q == STEP_W'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done     = done_q;
   assign quotient = num_q[Q_W-1:0];

   logic [PRD_W-1:0] chk_prod;
   logic [PRD_W-1:0] chk_lo;
   logic [PRD_W-1:0] chk_hi;
   assign chk_prod = PRD_W'(num_q) * PRD_W'(den_q);
   assign chk_lo   = PRD_W'(dvd_q);
   assign chk_hi   = PRD_W'(dvd_q) + PRD_W'(den_q);

   // R7: the result is the smallest q with q*den >= dividend
   a_r7_ceiling_quotient: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (chk_prod >= chk_lo) && (chk_prod < chk_hi));

   // R7: the averaging count is never zero
   a_r7_nonzero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (divisor != '0));
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
   import tsc_pkg::*;
#(
   parameter int NCH      = 8,
   parameter int SKIP_W   = 4,
   parameter int RATIO_W  = 4,
   parameter int HALF_DIV = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [NCH-1:0]           chan_en,
   input  logic [NCH*SKIP_W-1:0]    skip_cfg,
   input  logic [NCH*RATIO_W-1:0]   ratio_cfg,
   input  logic                     miso,
   output logic                     sclk,
   output logic                     mosi,
   output logic                     cs_n,
   output logic                     busy,
   output logic                     res_valid,
   output logic [ADDR_W-1:0]        res_chan,
   output logic [SAMPLE_W-1:0]      res_data,
   output logic                     scan_done
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int IDX_W = $clog2(NCH);
   localparam int CNT_W = ((SKIP_W > RATIO_W) ? SKIP_W : RATIO_W) + 1;
   localparam int ACC_W = SAMPLE_W + RATIO_W;

   if (NCH < 2 || NCH > (1 << ADDR_W)) begin : g_bad_nch
      $error("touch_scan_seq: NCH must lie between 2 and 8");
   end
   if (SKIP_W < 1 || RATIO_W < 1) begin : g_bad_cfg_w
      $error("touch_scan_seq: SKIP_W and RATIO_W must be at least 1");
   end

   seq_state_t           st_q;
   logic [NCH-1:0]       en_q;
   logic [NCH*SKIP_W-1:0]  skip_q;
   logic [NCH*RATIO_W-1:0] ratio_q;
   logic [IDX_W-1:0]     idx_q;
   logic [CNT_W-1:0]     fcnt_q;
   logic [CNT_W-1:0]     tot_q;
   logic [SKIP_W-1:0]    cur_skip_q;
   logic [RATIO_W-1:0]   cur_ratio_q;
   logic [ACC_W-1:0]     acc_q;
   logic                 frame_go_q;
   logic [CMD_W-1:0]     frame_cmd_q;
   logic                 div_go_q;
   logic                 cs_n_q;
   logic                 res_valid_q;
   logic [ADDR_W-1:0]    res_chan_q;
   logic [SAMPLE_W-1:0]  res_data_q;
   logic                 scan_done_q;

   logic                 frame_done;
   logic [SAMPLE_W-1:0]  frame_sample;
   logic                 div_done;
   logic [SAMPLE_W-1:0]  div_quot;

   // Per-channel views of the captured configuration.
   logic [SKIP_W-1:0]    skip_a  [NCH];
   logic [RATIO_W-1:0]   ratio_a [NCH];
   for (genvar g = 0; g < NCH; g++) begin : g_cfg
      assign skip_a[g]  = skip_q[g*SKIP_W +: SKIP_W];
      assign ratio_a[g] = ratio_q[g*RATIO_W +: RATIO_W];
   end

   logic [SKIP_W-1:0]  sel_skip;
   logic [RATIO_W-1:0] sel_ratio;
   logic [ADDR_W-1:0]  cur_addr;
   logic               last_frame;
   logic               last_chan;

   assign sel_skip   = skip_a[idx_q];
   assign sel_ratio  = (ratio_a[idx_q] == '0) ? RATIO_W'(1) : ratio_a[idx_q];
   assign cur_addr   = ADDR_W'(idx_q);
   assign last_frame = (fcnt_q == tot_q - CNT_W'(1));
   assign last_chan  = (idx_q == IDX_W'(NCH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         en_q        <= '0;
         skip_q      <= '0;
         ratio_q     <= '0;
         idx_q       <= '0;
         fcnt_q      <= '0;
         tot_q       <= '0;
         cur_skip_q  <= '0;
         cur_ratio_q <= '0;
         acc_q       <= '0;
         frame_go_q  <= 1'b0;
         frame_cmd_q <= '0;
         div_go_q    <= 1'b0;
         cs_n_q      <= 1'b1;
         res_valid_q <= 1'b0;
         res_chan_q  <= '0;
         res_data_q  <= '0;
         scan_done_q <= 1'b0;
      end else begin
         frame_go_q  <= 1'b0;
         div_go_q    <= 1'b0;
         res_valid_q <= 1'b0;
         scan_done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  en_q    <= chan_en;
                  skip_q  <= skip_cfg;
                  ratio_q <= ratio_cfg;
                  idx_q   <= '0;
                  cs_n_q  <= 1'b0;
                  st_q    <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (en_q[idx_q]) begin
                  cur_skip_q  <= sel_skip;
                  cur_ratio_q <= sel_ratio;
                  tot_q       <= CNT_W'(sel_skip) + CNT_W'(sel_ratio);
                  fcnt_q      <= '0;
                  acc_q       <= '0;
                  st_q        <= ST_ISSUE;
               end else if (last_chan) begin
                  st_q <= ST_FINISH;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_ISSUE: begin
               // converter stays powered until the final frame of the burst
               frame_go_q  <= 1'b1;
               frame_cmd_q <= make_cmd(cur_addr, !last_frame);
               st_q        <= ST_WAIT;
            end
            ST_WAIT: begin
               if (frame_done) begin
                  if (fcnt_q >= CNT_W'(cur_skip_q))
                     acc_q <= acc_q + ACC_W'(frame_sample);
                  fcnt_q <= fcnt_q + 1'b1;
                  if (last_frame) begin
                     div_go_q <= 1'b1;
                     st_q     <= ST_DIVIDE;
                  end else begin
                     st_q <= ST_ISSUE;
                  end
               end
            end
            ST_DIVIDE: begin
               if (div_done) begin
                  res_valid_q <= 1'b1;
                  res_chan_q  <= cur_addr;
                  res_data_q  <= div_quot;
                  if (last_chan) begin
                     st_q <= ST_FINISH;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= ST_PICK;
                  end
               end
            end
            ST_FINISH: begin
               scan_done_q <= 1'b1;
               cs_n_q      <= 1'b1;
               st_q        <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   tsc_spi_frame #(
      .HALF_DIV (HALF_DIV)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (frame_go_q),
      .cmd    (frame_cmd_q),
      .miso   (miso),
      .sclk   (sclk),
      .mosi   (mosi),
      .sample (frame_sample),
      .done   (frame_done)
   );

   tsc_ceil_div #(
      .NUM_W (ACC_W),
      .DEN_W (RATIO_W),
      .Q_W   (SAMPLE_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_go_q),
      .dividend (acc_q),
      .divisor  (cur_ratio_q),
      .done     (div_done),
      .quotient (div_quot)
   );

   assign cs_n      = cs_n_q;
   assign busy      = (st_q != ST_IDLE);
   assign res_valid = res_valid_q;
   assign res_chan  = res_chan_q;
   assign res_data  = res_data_q;
   assign scan_done = scan_done_q;

   // Ordering tracker used only by the checks below.
   logic              seen_q;
   logic [ADDR_W-1:0] prev_chan_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q      <= 1'b0;
         prev_chan_q <= '0;
      end else if (st_q == ST_IDLE && start) begin
         seen_q <= 1'b0;
      end else if (res_valid_q) begin
         seen_q      <= 1'b1;
         prev_chan_q <= res_chan_q;
      end
   end

   // R1: the serial clock only toggles inside a chip-select window
   a_r1_cs_covers_sclk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);

   // R8: results come out in strictly increasing address order
   a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_q && seen_q) |-> (res_chan_q > prev_chan_q));

   // R8: only enabled channels report
   a_r8_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_q |-> en_q[IDX_W'(res_chan_q)]);

   // R9: the done strobe coincides with the released bus and an idle sequencer
   a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done_q |-> (cs_n && !busy && !res_valid_q));

   // R10: captured configuration is frozen for the whole scan
   a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(en_q) && $stable(skip_q) && $stable(ratio_q)));

   // R4: the frame that closes a burst carries the power-down command
   a_r4_last_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
      div_go_q |-> !frame_cmd_q[0]);
endmodule

// File: tb/sim_touch_scan_seq.sv
module sim_touch_scan_seq;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NCH = 8;
   localparam int SW  = 4;
   localparam int RW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [NCH-1:0]  chan_en = '0;
   logic [NCH*SW-1:0] skip_cfg = '0;
   logic [NCH*RW-1:0] ratio_cfg = '0;
   logic            miso = 1'b0;
   logic            sclk, mosi, cs_n, busy, res_valid, scan_done;
   logic [2:0]      res_chan;
   logic [11:0]     res_data;

   int total = 0;
   int bad = 0;
   int skip_c [NCH];
   int ratio_c [NCH];
   bit full = 1'b0;
   logic clr = 1'b0;

   always #2.5 clk = ~clk;

   touch_scan_seq #(.NCH(NCH), .SKIP_W(SW), .RATIO_W(RW), .HALF_DIV(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
      .skip_cfg(skip_cfg), .ratio_cfg(ratio_cfg), .miso(miso),
      .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
      .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
      .scan_done(scan_done)
   );

   // Sample produced by the converter model for a channel and a frame position.
   function automatic int samp(input int a, input int k);
      if (full) return 4095;
      return (a * 613 + k * 389 + 77) % 4096;
   endfunction

   function automatic int cmd_exp(input int a, input bit last);
      int v;
      v = 128 + a * 16;
      if (a == 0 || a == 2 || a == 6 || a == 7) v += 6;
      if (!last) v += 1;
      return v;
   endfunction

   // Converter model: shifts in the command, answers with padding bits set.
   int rcnt = 0;
   int nfr = 0;
   int rises = 0;
   int nlog = 0;
   logic [7:0]  cmd_sh = '0;
   logic [15:0] resp = '0;
   logic [7:0]  cmd_log [256];

   always @(posedge sclk or negedge sclk or posedge clr) begin
      if (clr) begin
         rcnt = 0; nfr = 0; rises = 0; nlog = 0; miso = 1'b0;
      end else if (sclk) begin
         rises++;
         if (rcnt < 8) cmd_sh = {cmd_sh[6:0], mosi};
         rcnt++;
         if (rcnt == 8) begin
            cmd_log[nlog] = cmd_sh;
            nlog++;
            resp = {1'b1, 12'(samp(int'(cmd_sh[6:4]), nfr)), 3'b101};
         end
      end else begin
         if (rcnt >= 8 && rcnt < 24) miso = resp[23-rcnt];
         else if (rcnt >= 24) begin
            rcnt = 0; nfr++; miso = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic run_scan(input logic [7:0] m, input bit poke);
      int fidx, nexp, got, csbad, mism;
      int exp_ch [8];
      int exp_val [8];
      int exp_cmd [256];
      bit done_seen;
      fidx = 0; nexp = 0;
      for (int c = 0; c < NCH; c++) begin
         if (m[c]) begin
            int r, tot, sum;
            r = (ratio_c[c] == 0) ? 1 : ratio_c[c];
            tot = skip_c[c] + r;
            sum = 0;
            for (int j = 0; j < tot; j++) begin
               exp_cmd[fidx+j] = cmd_exp(c, j == tot - 1);
               if (j >= skip_c[c]) sum += samp(c, fidx + j);
            end
            fidx += tot;
            exp_val[nexp] = (sum + r - 1) / r;
            exp_ch[nexp] = c;
            nexp++;
         end
      end
      for (int c = 0; c < NCH; c++) begin
         skip_cfg[c*SW +: SW]  = SW'(skip_c[c]);
         ratio_cfg[c*RW +: RW] = RW'(ratio_c[c]);
      end
      clr = 1'b1; #0.5; clr = 1'b0;
      chan_en = m;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check(cs_n == 1'b0, "R1 cs low after start", int'(cs_n), 0);
      got = 0; csbad = 0; done_seen = 1'b0;
      for (int cyc = 0; cyc < 30000 && !done_seen; cyc++) begin
         @(negedge clk);
         if (poke && cyc == 20) begin
            start = 1'b1; chan_en = ~m;
            skip_cfg = '0; ratio_cfg = '1;
         end else begin
            start = 1'b0; chan_en = m;
         end
         if (sclk && cs_n) csbad++;
         if (res_valid) begin
            if (got < nexp) begin
               check(res_chan == 3'(exp_ch[got]), "R8 result channel", int'(res_chan), exp_ch[got]);
               check(res_data == 12'(exp_val[got]), "R6 R7 averaged value", int'(res_data), exp_val[got]);
            end
            got++;
         end
         if (scan_done) begin
            done_seen = 1'b1;
            check(cs_n == 1'b1 && busy == 1'b0, "R9 released at done", int'(cs_n), 1);
         end
      end
      start = 1'b0; chan_en = m;
      check(done_seen, "R9 scan_done seen", int'(done_seen), 1);
      check(got == nexp, "R8 result count", got, nexp);
      check(nfr == fidx, "R5 frame count", nfr, fidx);
      check(rises == 24 * fidx, "R5 sclk periods", rises, 24 * fidx);
      check(csbad == 0, "R1 sclk outside cs", csbad, 0);
      mism = 0;
      for (int i = 0; i < nlog && i < 256; i++)
         if (int'(cmd_log[i]) != exp_cmd[i]) mism++;
      // R2 MSB-first command capture on rising edges, R3 layout, R4 power bit
      check(nlog == fidx && mism == 0, "R2 R3 R4 command bytes mismatched", mism, 0);
      if (poke) begin
         repeat (10) @(negedge clk);
         check(cs_n == 1'b1 && busy == 1'b0 && rises == 24 * fidx,
               "R10 start during scan ignored", rises, 24 * fidx);
      end
   endtask

   task automatic run_all();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(cs_n == 1'b1, "R11 cs_n after reset", int'(cs_n), 1);
      check(sclk == 1'b0 && mosi == 1'b0, "R11 sclk mosi after reset", int'(sclk), 0);
      check(busy == 1'b0 && res_valid == 1'b0 && scan_done == 1'b0,
            "R11 strobes after reset", int'(busy), 0);

      // default settings, every channel
      for (int c = 0; c < NCH; c++) begin skip_c[c] = 1; ratio_c[c] = 1; end
      run_scan(8'hFF, 1'b0);

      // mixed settling and ratios
      for (int c = 0; c < NCH; c++) begin skip_c[c] = c % 4; ratio_c[c] = c + 1; end
      run_scan(8'hA6, 1'b0);

      // ratio field 0 behaves as 1 (R5)
      for (int c = 0; c < NCH; c++) begin skip_c[c] = 0; ratio_c[c] = 0; end
      run_scan(8'h81, 1'b0);

      // full scale at the largest ratio, no overflow (R7)
      full = 1'b1;
      for (int c = 0; c < NCH; c++) begin skip_c[c] = 0; ratio_c[c] = 15; end
      skip_c[7] = 3;
      run_scan(8'h80, 1'b0);
      full = 1'b0;

      // empty mask (R9)
      run_scan(8'h00, 1'b0);

      // start and configuration changes during a scan (R10)
      for (int c = 0; c < NCH; c++) begin skip_c[c] = 2; ratio_c[c] = 3; end
      run_scan(8'h24, 1'b1);

      // near-exhaustive mask sweep
      for (int c = 0; c < NCH; c++) begin skip_c[c] = c % 2; ratio_c[c] = (c % 3) + 1; end
      for (int m = 1; m < 256; m += 7) run_scan(8'(m), 1'b0);
   endtask

   initial begin
      bit wd;
      wd = 1'b0;
      fork
         run_all();
         begin
            repeat (190000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      if (wd) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule